// File: doc/BRIEF.md
# Multimode UART Core with Address Filtering

This core sends and receives asynchronous serial frames in one of three framings, picked by a two-bit mode field. The first is an 8-bit frame at a programmable rate. The second is a 9-bit frame at a fixed rate of one sixteenth of the enabled system clock. The third is a 9-bit frame at a programmable rate. The fourth mode code selects synchronous shifting. The core accepts that code as a setting, but in that mode it neither sends nor receives.

For multi-drop links, an address-filter enable stops the receive interrupt for frames that a node should skip. In the 9-bit framings it lets through only frames whose ninth bit is 1. In the 8-bit framing it lets through only frames that end with a valid stop bit. Filtered frames still update the received byte and ninth bit. An optional parity mode replaces the software-supplied ninth bit with even parity on transmit and checks it on receive.

The receiver oversamples at sixteen times the bit rate and samples each bit at mid-bit. The transmitter pulses a done strobe once the stop bit has been fully sent.

Top module: `mmu_uart`

## Requirements
- R1: After reset, tx_o is 1 and rx_irq_o, tx_done_o, rx_data_o and rx_bit9_o are all 0.
- R2: A frame is one start bit (0), then the data bits LSB first, then a ninth bit only when mode_i[1] is 1, then one stop bit (1). A looped-back frame delivers the transmitted byte on rx_data_o.
- R3: One bit lasts 16 oversample ticks. With mode_i = 2'b10 a tick is every clk_en_i pulse. With mode_i = 2'b01 or 2'b11 a tick is every baud_div_i+1 clk_en_i pulses. A frame therefore lasts 16 × ticks-per-bit × (10 or 11) enabled pulses.
- R4: With mode_i = 2'b10 or 2'b11 and par_en_i = 0, the sent ninth bit equals tx_bit9_i and the received ninth bit appears on rx_bit9_o. With mode_i = 2'b01, tx_bit9_i has no effect and rx_bit9_o reads 0.
- R5: With par_en_i = 1 in a 9-bit mode, the sent ninth bit is the XOR of the 8 data bits (even parity). rx_bit9_o then reads 1 on a parity mismatch and 0 otherwise.
- R6: In a 9-bit mode with addr_filt_i = 1 and par_en_i = 0, rx_irq_o pulses only for frames whose ninth bit is 1.
- R7: In mode 2'b01 with addr_filt_i = 1, rx_irq_o pulses only when the stop bit is sampled as 1. With addr_filt_i = 0, it pulses for every frame.
- R8: A frame whose interrupt is filtered still updates rx_data_o and rx_bit9_o.
- R9: While rx_en_i is 0, no frame is captured: rx_data_o does not change and rx_irq_o stays 0.
- R10: A start edge whose line is no longer low at mid-bit is dropped, and no frame is captured.
- R11: In mode 2'b00, tx_start_i has no effect (tx_o stays 1 and no done pulse occurs), no frame is received, and addr_filt_i has no effect.
- R12: tx_done_o is a single-cycle pulse that follows the stop bit, and tx_start_i is ignored while a frame is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | System clock enable that drives the baud timing |
| mode_i | input | 2 | Frame mode: 00 sync (idle), 01 8-bit, 10 9-bit fixed rate, 11 9-bit programmable rate |
| addr_filt_i | input | 1 | Address-filter enable for the receive interrupt |
| rx_en_i | input | 1 | Receive enable |
| par_en_i | input | 1 | Even-parity ninth bit in the 9-bit modes |
| tx_bit9_i | input | 1 | Ninth bit to send when parity is off |
| baud_div_i | input | DIV_W | Rate divisor; ticks-per-bit factor is baud_div_i+1 |
| tx_start_i | input | 1 | Start sending tx_data_i |
| tx_data_i | input | 8 | Byte to send |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| rx_data_o | output | 8 | Last received byte |
| rx_bit9_o | output | 1 | Received ninth bit, or parity-error flag when parity is on |
| tx_done_o | output | 1 | One-cycle pulse after the stop bit |
| rx_irq_o | output | 1 | One-cycle receive interrupt, after filtering |

## Verification
The properties assume that mode_i, addr_filt_i, par_en_i and rx_en_i stay fixed while a frame is in flight. They also assume that rx_i carries only well-spaced frames at the configured rate. Under those assumptions, a gated interrupt can be related to the current ninth bit and control values. The stimulus changes configuration only after both the transmit done pulse and the receive sample point have passed. Hand-driven frames keep each bit for a full bit period. The one exception is a deliberately short bad stop bit: it is held low past the sample point but released before a re-detected start could be sampled at mid-bit.

// File: rtl/mmu_uart_pkg.sv
package mmu_uart_pkg;
  typedef enum logic [1:0] {
    MODE_SYNC   = 2'b00,
    MODE_A8     = 2'b01,
    MODE_A9_FIX = 2'b10,
    MODE_A9_VAR = 2'b11
  } mode_e;

  localparam int unsigned OVS      = 16;
  localparam int unsigned CNT_W    = $clog2(OVS);
  localparam logic [CNT_W-1:0] MID_TICK = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] END_TICK = CNT_W'(OVS - 1);

  function automatic logic has_bit9(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic is_async(input logic [1:0] m);
    return m != MODE_SYNC;
  endfunction
endpackage

// File: rtl/mmu_uart_baud.sv
module mmu_uart_baud #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clk_en_i,
  input  logic             fixed_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (clk_en_i) begin
        // >= so a divisor lowered mid-count cannot stall the counter
        if (fixed_i || cnt_q >= div_i) begin
          cnt_q  <= '0;
          tick_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/mmu_uart_rx.sv
module mmu_uart_rx
  import mmu_uart_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rx_i,
  input  logic [1:0] mode_i,
  input  logic       rx_en_i,
  input  logic       filt_i,
  input  logic       par_en_i,
  output logic [7:0] data_o,
  output logic       bit9_o,
  output logic       irq_o
);
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_st_e;

  rx_st_e           st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       idx_q;
  logic [8:0]       sh_q;
  logic             s1_q, s2_q;
  logic [7:0]       data_q;
  logic             bit9_q, irq_q;

  logic       wide;
  logic [3:0] last_idx;
  logic [7:0] frame_byte;
  logic       raw9, pass;

  assign wide       = has_bit9(mode_i);
  assign last_idx   = wide ? 4'd8 : 4'd7;
  assign frame_byte = wide ? sh_q[7:0] : sh_q[8:1];
  assign raw9       = sh_q[8];
  // ninth-bit gate in 9-bit modes (parity replaces it), stop-bit gate in 8-bit mode
  assign pass       = !filt_i || (wide ? (par_en_i || raw9) : s2_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= rx_i;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      data_q <= '0;
      bit9_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (!rx_en_i || !is_async(mode_i)) begin
        st_q <= RX_IDLE;
      end else if (tick_i) begin
        cnt_q <= cnt_q + 1'b1;
        unique case (st_q)
          RX_IDLE: begin
            if (!s2_q) begin
              st_q  <= RX_START;
              cnt_q <= '0;
            end
          end
          RX_START: begin
            if (cnt_q == MID_TICK) begin
              if (s2_q) st_q <= RX_IDLE;
              else begin
                st_q  <= RX_BITS;
                idx_q <= '0;
              end
            end
          end
          RX_BITS: begin
            if (cnt_q == MID_TICK) begin
              sh_q  <= {s2_q, sh_q[8:1]};
              idx_q <= idx_q + 1'b1;
              if (idx_q == last_idx) st_q <= RX_STOP;
            end
          end
          RX_STOP: begin
            if (cnt_q == MID_TICK) begin
              st_q   <= RX_IDLE;
              data_q <= frame_byte;
              bit9_q <= wide && (par_en_i ? (raw9 ^ (^frame_byte)) : raw9);
              irq_q  <= pass;
            end
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign data_o = data_q;
  assign bit9_o = bit9_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/mmu_uart_tx.sv
module mmu_uart_tx
  import mmu_uart_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [1:0] mode_i,
  input  logic       par_en_i,
  input  logic       bit9_i,
  input  logic       start_i,
  input  logic [7:0] data_i,
  output logic       tx_o,
  output logic       done_o
);
  logic             busy_q, done_q;
  logic [10:0]      sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       left_q;
  logic             nine;

  assign nine = par_en_i ? ^data_i : bit9_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
      left_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i && is_async(mode_i)) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
          if (has_bit9(mode_i)) begin
            sh_q   <= {1'b1, nine, data_i, 1'b0};
            left_q <= 4'd11;
          end else begin
            sh_q   <= {2'b11, data_i, 1'b0};
            left_q <= 4'd10;
          end
        end
      end else if (tick_i) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == END_TICK) begin
          sh_q   <= {1'b1, sh_q[10:1]};
          left_q <= left_q - 1'b1;
          if (left_q == 4'd1) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign tx_o   = busy_q ? sh_q[0] : 1'b1;
  assign done_o = done_q;
endmodule

// File: rtl/mmu_uart.sv
module mmu_uart
  import mmu_uart_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clk_en_i,
  input  logic [1:0]       mode_i,
  input  logic             addr_filt_i,
  input  logic             rx_en_i,
  input  logic             par_en_i,
  input  logic             tx_bit9_i,
  input  logic [DIV_W-1:0] baud_div_i,
  input  logic             tx_start_i,
  input  logic [7:0]       tx_data_i,
  input  logic             rx_i,
  output logic             tx_o,
  output logic [7:0]       rx_data_o,
  output logic             rx_bit9_o,
  output logic             tx_done_o,
  output logic             rx_irq_o
);
  logic tick;
  logic filt_eff;

  // filter forced off outside the asynchronous modes
  assign filt_eff = addr_filt_i && is_async(mode_i);

  mmu_uart_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clk_en_i (clk_en_i),
    .fixed_i  (mode_i == MODE_A9_FIX),
    .div_i    (baud_div_i),
    .tick_o   (tick)
  );

  mmu_uart_tx u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .mode_i   (mode_i),
    .par_en_i (par_en_i),
    .bit9_i   (tx_bit9_i),
    .start_i  (tx_start_i),
    .data_i   (tx_data_i),
    .tx_o     (tx_o),
    .done_o   (tx_done_o)
  );

  mmu_uart_rx u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .rx_i     (rx_i),
    .mode_i   (mode_i),
    .rx_en_i  (rx_en_i),
    .filt_i   (filt_eff),
    .par_en_i (par_en_i),
    .data_o   (rx_data_o),
    .bit9_o   (rx_bit9_o),
    .irq_o    (rx_irq_o)
  );
endmodule

// File: rtl/mmu_uart_chk.sv
module mmu_uart_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       addr_filt_i,
  input logic       rx_en_i,
  input logic       par_en_i,
  input logic       tx_o,
  input logic       rx_bit9_o,
  input logic       tx_done_o,
  input logic       rx_irq_o
);
  // R12
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |=> !tx_done_o);

  // R2
  idle_after_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |-> tx_o);

  // R7
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |=> !rx_irq_o);

  // R9
  irq_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> $past(rx_en_i));

  // R6
  addr_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_irq_o && mode_i[1] && addr_filt_i && !par_en_i) |-> rx_bit9_o);

  // R4
  no_bit9_a8_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_irq_o && mode_i == 2'b01) |-> !rx_bit9_o);

  // R11
  sync_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) == 2'b00) |-> !rx_irq_o);
endmodule

bind mmu_uart mmu_uart_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .addr_filt_i (addr_filt_i),
  .rx_en_i     (rx_en_i),
  .par_en_i    (par_en_i),
  .tx_o        (tx_o),
  .rx_bit9_o   (rx_bit9_o),
  .tx_done_o   (tx_done_o),
  .rx_irq_o    (rx_irq_o)
);

// File: tb/sim_mmu_uart.sv
`timescale 1ns/1ps
module sim_mmu_uart;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_en = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       filt = 1'b0, rx_en = 1'b0, par = 1'b0, b9 = 1'b0;
  logic [7:0] div = 8'd1;
  logic       tx_start = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       loop = 1'b1, drv_rx = 1'b1;
  logic       rx_line, tx_line;
  logic [7:0] rx_data;
  logic       rx_bit9, tx_done, rx_irq;

  int checks = 0, errors = 0;
  int irq_cnt = 0, done_cnt = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  assign rx_line = loop ? tx_line : drv_rx;

  mmu_uart u0 (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_i(clk_en), .mode_i(mode),
    .addr_filt_i(filt), .rx_en_i(rx_en), .par_en_i(par), .tx_bit9_i(b9),
    .baud_div_i(div), .tx_start_i(tx_start), .tx_data_i(tx_data),
    .rx_i(rx_line), .tx_o(tx_line), .rx_data_o(rx_data),
    .rx_bit9_o(rx_bit9), .tx_done_o(tx_done), .rx_irq_o(rx_irq)
  );

  always @(posedge clk) begin
    if (rx_irq) irq_cnt <= irq_cnt + 1;
    if (tx_done) done_cnt <= done_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_tx(input logic [7:0] d, output int dur);
    int base;
    base = done_cnt;
    tx_data = d;
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    dur = 1;
    while (done_cnt == base && dur < 5000) begin
      @(negedge clk);
      dur++;
    end
  endtask

  // bits LSB first; the final bit is held last_len cycles, then idle high
  task automatic drive_bits(input logic [10:0] b, input int n, input int per, input int last_len);
    for (int i = 0; i < n; i++) begin
      drv_rx = b[i];
      repeat ((i == n - 1) ? last_len : per) @(negedge clk);
    end
    drv_rx = 1'b1;
    repeat (3 * per) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int dur, i0, nb, rate, exp_dur;
    logic [7:0] d;
    logic e9, eirq;
    logic [10:0] fr;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(tx_line == 1'b1, "R1 tx idle", tx_line, 1);
    chk(rx_irq == 1'b0 && tx_done == 1'b0, "R1 pulses low", rx_irq + tx_done, 0);
    chk(rx_data == 8'h00 && rx_bit9 == 1'b0, "R1 rx regs", rx_data, 0);
    rst_n = 1'b1;
    rx_en = 1'b1;
    repeat (4) @(negedge clk);

    // sweep: modes x filter x parity x ninth bit x bytes (R2 R3 R4 R5 R6 R7 R8)
    for (int m = 1; m < 4; m++) begin
      for (int cfg = 0; cfg < 8; cfg++) begin
        mode = 2'(m);
        filt = cfg[0];
        par  = cfg[1];
        b9   = cfg[2];
        div  = 8'd1;
        repeat (4) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
          d = 8'((k * 37 + 5) & 255);
          i0 = irq_cnt;
          send_tx(d, dur);
          repeat (6) @(negedge clk);
          nb   = (m == 1) ? 10 : 11;
          rate = (m == 2) ? 1 : 2;
          exp_dur = nb * 16 * rate;
          e9   = (m == 1) ? 1'b0 : (par ? 1'b0 : b9);
          eirq = (m == 1) ? 1'b1 : (!filt || par || b9);
          chk(rx_data == d, "R2/R8 rx byte", rx_data, d);
          chk(rx_bit9 == e9, "R4/R5 rx ninth bit", rx_bit9, e9);
          chk((irq_cnt - i0) == int'(eirq), "R6/R7 irq gating", irq_cnt - i0, eirq);
          chk(dur >= exp_dur - 2 && dur <= exp_dur + 3, "R3 frame length", dur, exp_dur);
        end
      end
    end

    // R3: larger divisor, mode 11
    mode = 2'b11; filt = 1'b0; par = 1'b0; div = 8'd3;
    repeat (8) @(negedge clk);
    send_tx(8'h5A, dur);
    chk(dur >= 704 - 2 && dur <= 704 + 5, "R3 div 3 length", dur, 704);
    repeat (40) @(negedge clk);

    // R3: fixed-rate mode ignores divisor, follows clk_en
    mode = 2'b10; div = 8'd7; clk_en = 1'b0;
    fork
      begin
        while (!finished && mode == 2'b10 && div == 8'd7) begin
          @(negedge clk); clk_en = ~clk_en;
        end
      end
      begin
        repeat (4) @(negedge clk);
        send_tx(8'hC3, dur);
        chk(dur >= 352 - 3 && dur <= 352 + 4, "R3 half clk_en length", dur, 352);
        repeat (20) @(negedge clk);
        div = 8'd1;
      end
    join
    clk_en = 1'b1;
    repeat (10) @(negedge clk);

    // R5: parity mismatch detected, mode 11 div 1 (32 cycles/bit)
    loop = 1'b0; mode = 2'b11; par = 1'b1; filt = 1'b1;
    repeat (10) @(negedge clk);
    i0 = irq_cnt;
    fr = {1'b1, 1'b1, 8'h03, 1'b0};
    drive_bits(fr, 11, 32, 32);
    chk(rx_data == 8'h03, "R5 byte", rx_data, 3);
    chk(rx_bit9 == 1'b1, "R5 parity error flag", rx_bit9, 1);
    chk(irq_cnt - i0 == 1, "R5 irq with parity", irq_cnt - i0, 1);

    // R7/R8: bad stop in mode 01 with filter
    mode = 2'b01; par = 1'b0; filt = 1'b1;
    repeat (10) @(negedge clk);
    i0 = irq_cnt;
    fr = {2'b11, 1'b0, 8'hA5, 1'b0};
    drive_bits(fr, 10, 32, 24);
    chk(rx_data == 8'hA5, "R8 filtered byte stored", rx_data, 8'hA5);
    chk(irq_cnt - i0 == 0, "R7 bad stop filtered", irq_cnt - i0, 0);
    filt = 1'b0;
    repeat (10) @(negedge clk);
    i0 = irq_cnt;
    fr = {2'b11, 1'b0, 8'h96, 1'b0};
    drive_bits(fr, 10, 32, 24);
    chk(rx_data == 8'h96, "R7 byte no filter", rx_data, 8'h96);
    chk(irq_cnt - i0 == 1, "R7 bad stop unfiltered irq", irq_cnt - i0, 1);

    // R10: glitch start rejected
    i0 = irq_cnt;
    drive_bits(11'h000, 1, 32, 8);
    repeat (400) @(negedge clk);
    chk(irq_cnt - i0 == 0, "R10 glitch no irq", irq_cnt - i0, 0);
    chk(rx_data == 8'h96, "R10 glitch data kept", rx_data, 8'h96);

    // R9: receive disabled
    mode = 2'b11; rx_en = 1'b0;
    repeat (10) @(negedge clk);
    i0 = irq_cnt;
    fr = {1'b1, 1'b1, 8'h3C, 1'b0};
    drive_bits(fr, 11, 32, 32);
    chk(irq_cnt - i0 == 0, "R9 no irq when disabled", irq_cnt - i0, 0);
    chk(rx_data == 8'h96, "R9 data kept", rx_data, 8'h96);
    rx_en = 1'b1;

    // R11: mode 00 quiet
    mode = 2'b00; filt = 1'b1;
    repeat (10) @(negedge clk);
    i0 = irq_cnt;
    drive_bits(fr, 11, 32, 32);
    chk(irq_cnt - i0 == 0, "R11 no rx in mode 00", irq_cnt - i0, 0);
    chk(rx_data == 8'h96, "R11 data kept", rx_data, 8'h96);
    loop = 1'b1;
    i0 = done_cnt;
    tx_data = 8'h00; tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    for (int t = 0; t < 4; t++) begin
      repeat (20) @(negedge clk);
      chk(tx_line == 1'b1, "R11 tx stays high", tx_line, 1);
    end
    repeat (400) @(negedge clk);
    chk(done_cnt - i0 == 0, "R11 no done in mode 00", done_cnt - i0, 0);

    // R12: start while busy ignored, done one pulse
    mode = 2'b10; filt = 1'b0;
    repeat (10) @(negedge clk);
    i0 = done_cnt;
    tx_data = 8'h11; tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    repeat (50) @(negedge clk);
    tx_data = 8'h22; tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    repeat (500) @(negedge clk);
    chk(done_cnt - i0 == 1, "R12 single done", done_cnt - i0, 1);
    chk(rx_data == 8'h11, "R12 busy start ignored", rx_data, 8'h11);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule